// File: doc/BRIEF.md
# Burst-of-Four SRAM Read Path

This block models the read side of a synchronous burst memory that has separate read and write ports. A read is requested by pulling an active-low select low on an input-clock rising edge together with a group address. The block then fetches the four words of that group from its internal array and places them on a double-rate data bus, one word per half input cycle. It raises a valid flag for exactly those four beats and drives the bus only while its output-enable is high.

Double-rate timing uses one fast clock running at twice the input-clock rate. A phase input, `kPhase`, marks the fast cycles whose rising edge is the input-clock rising edge. Control inputs are sampled only on those edges. A static mode input selects the first-word latency: 1.5 input cycles in normal mode, 1 input cycle in legacy mode. A simple synchronous write port fills the array.

Top module: `burst_rd_sram`

## Requirements
- R1: A read is accepted on a fast-clock edge where `kPhase` is 1, `rdSelN` is 0 and no read was accepted on the previous `kPhase` edge. The group address on `rdAddr` is captured at that edge, and later values of `rdAddr` do not affect the burst.
- R2: Every accepted read returns four words on consecutive fast cycles. They are array entries {group, 2'd0}, {group, 2'd1}, {group, 2'd2} and {group, 2'd3}, in that order, so the group forms the upper address bits and the beat index the lower two.
- R3: A request on the `kPhase` edge directly after an accepted request is dropped. It produces no beats and its address is never read.
- R4: Requests accepted on every other `kPhase` edge produce an unbroken run of valid beats, with no idle cycle between bursts.
- R5: With `legacyMode`=0 the first word is visible after the third fast-clock edge following the accepting edge. With `legacyMode`=1 it is visible after the second.
- R6: `dataValid` is 1 after exactly the four edges that load a burst's words, and 0 otherwise.
- R7: `outEnable` is 1 whenever `dataValid` is 1. When a burst ends it stays high until the first edge with `kPhase`=1 that loads no word, and is cleared there. While `outEnable` is 0, `rdData` is high impedance.
- R8: A synchronous reset (`rst`=1) clears `dataValid`, `outEnable`, the pending request state and any burst in flight.
- R9: When `wrEn` is 1, `wrData` is written to array entry `wrAddr` on the rising edge of `clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, twice the input-clock rate |
| rst | input | 1 | Synchronous reset, active high |
| kPhase | input | 1 | 1 when this edge is an input-clock rising edge |
| legacyMode | input | 1 | Static latency select: 0 = 1.5 cycles, 1 = 1 cycle |
| rdSelN | input | 1 | Read select, active low |
| rdAddr | input | GROUP_AW | Group address of the read |
| wrEn | input | 1 | Write enable |
| wrAddr | input | GROUP_AW+2 | Word address of the write |
| wrData | input | DW | Write data |
| rdData | output | DW | Double-rate read data, high impedance when not enabled |
| dataValid | output | 1 | Read data beat valid |
| outEnable | output | 1 | Read bus driven |

## Verification
The assertions assume that `kPhase` alternates 1, 0, 1, 0 on consecutive fast-clock edges. They also assume that `legacyMode` changes only while no request or burst is in flight. The bench drives `kPhase` from the parity of its own edge counter and changes the mode only after several idle input cycles. It places every request on a `kPhase` edge and puts a different address on the following edge, so address capture is exercised. It sweeps all groups in both modes, issues consecutive and continuous requests to reach the drop rule, and resets in the middle of a burst.

// File: rtl/burst_rd_pkg.sv
package burst_rd_pkg;
  localparam int BEATS = 4;
  localparam int BEAT_W = $clog2(BEATS);

  typedef struct packed {
    logic accept;
    logic launch;
    logic emit;
    logic [BEAT_W-1:0] beatSel;
  } rdStrobes_t;
endpackage

// File: rtl/burst_rd_ctrl.sv
module burst_rd_ctrl
  import burst_rd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       kPhase,
  input  logic       legacyMode,
  input  logic       rdSelN,
  output rdStrobes_t stb
);
  localparam int PIPE = 3;

  logic              blockNext;
  logic [PIPE-1:0]   startPipe;
  logic              running;
  logic [BEAT_W-1:0] beatCnt;

  always_comb begin
    stb.accept  = kPhase & ~rdSelN & ~blockNext;
    stb.launch  = legacyMode ? startPipe[PIPE-2] : startPipe[PIPE-1];
    stb.emit    = stb.launch | running;
    stb.beatSel = stb.launch ? '0 : beatCnt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      blockNext <= 1'b0;
      startPipe <= '0;
      running   <= 1'b0;
      beatCnt   <= '0;
    end else begin
      startPipe <= {startPipe[PIPE-2:0], stb.accept};
      if (kPhase) blockNext <= stb.accept;
      if (stb.emit) begin
        beatCnt <= stb.beatSel + BEAT_W'(1);
        running <= (stb.beatSel != BEAT_W'(BEATS-1));
      end
    end
  end

  // R3: the input edge after an acceptance never accepts
  a_r3_drop_next: assert property (@(posedge clk) disable iff (rst)
    stb.accept |-> ##2 !stb.accept);

  // R4: a new burst starts only after the previous one has finished
  a_r4_no_overlap: assert property (@(posedge clk) disable iff (rst)
    !(stb.launch && running));

  // R5: legacy mode launches two fast edges after acceptance
  a_r5_legacy_lat: assert property (@(posedge clk) disable iff (rst)
    (stb.accept && legacyMode) |-> ##2 stb.launch);

  // R5: normal mode launches three fast edges after acceptance
  a_r5_normal_lat: assert property (@(posedge clk) disable iff (rst)
    (stb.accept && !legacyMode) |-> ##3 stb.launch);
endmodule

// File: rtl/burst_rd_dpath.sv
module burst_rd_dpath
  import burst_rd_pkg::*;
#(
  parameter int DW       = 18,
  parameter int GROUP_AW = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       kPhase,
  input  rdStrobes_t                 stb,
  input  logic [GROUP_AW-1:0]        rdAddr,
  input  logic                       wrEn,
  input  logic [GROUP_AW+BEAT_W-1:0] wrAddr,
  input  logic [DW-1:0]              wrData,
  output logic [DW-1:0]              qData,
  output logic                       validQ,
  output logic                       outEnQ
);
  localparam int AW    = GROUP_AW + BEAT_W;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0]       mem [DEPTH];
  logic [GROUP_AW-1:0] addrReg;
  logic [GROUP_AW-1:0] burstGrp;
  logic [GROUP_AW-1:0] grpSel;
  logic [AW-1:0]       rdIdx;

  always_ff @(posedge clk) begin
    if (wrEn) mem[wrAddr] <= wrData;
  end

  always_comb begin
    grpSel = stb.launch ? addrReg : burstGrp;
    rdIdx  = {grpSel, stb.beatSel};
  end

  always_ff @(posedge clk) begin
    if (stb.accept) addrReg <= rdAddr;
    if (stb.launch) burstGrp <= addrReg;
    if (stb.emit) qData <= mem[rdIdx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      validQ <= 1'b0;
      outEnQ <= 1'b0;
    end else begin
      validQ <= stb.emit;
      if (stb.emit) outEnQ <= 1'b1;
      else if (kPhase) outEnQ <= 1'b0;
    end
  end

  // R1: the captured group is the address presented at the accepting edge
  a_r1_capture: assert property (@(posedge clk) disable iff (rst)
    stb.accept |=> addrReg == $past(rdAddr));

  // R6: a launch yields four valid beats
  a_r6_four_beats: assert property (@(posedge clk) disable iff (rst)
    stb.launch |=> validQ ##1 validQ ##1 validQ ##1 validQ);

  // R7: the bus is driven whenever data is valid
  a_r7_oe_covers: assert property (@(posedge clk) disable iff (rst)
    validQ |-> outEnQ);

  // R7: the enable falls only on an input-clock edge or by reset
  a_r7_oe_falls_k: assert property (@(posedge clk) disable iff (rst)
    $fell(outEnQ) |-> ($past(kPhase) || $past(rst)));
endmodule

// File: rtl/burst_rd_sram.sv
module burst_rd_sram
  import burst_rd_pkg::*;
#(
  parameter int DW       = 18,
  parameter int GROUP_AW = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       kPhase,
  input  logic                       legacyMode,
  input  logic                       rdSelN,
  input  logic [GROUP_AW-1:0]        rdAddr,
  input  logic                       wrEn,
  input  logic [GROUP_AW+BEAT_W-1:0] wrAddr,
  input  logic [DW-1:0]              wrData,
  output logic [DW-1:0]              rdData,
  output logic                       dataValid,
  output logic                       outEnable
);
  rdStrobes_t    stb;
  logic [DW-1:0] qData;

  burst_rd_ctrl ctrl_i (
    .clk(clk), .rst(rst), .kPhase(kPhase), .legacyMode(legacyMode),
    .rdSelN(rdSelN), .stb(stb)
  );

  burst_rd_dpath #(.DW(DW), .GROUP_AW(GROUP_AW)) dpath_i (
    .clk(clk), .rst(rst), .kPhase(kPhase), .stb(stb), .rdAddr(rdAddr),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .qData(qData), .validQ(dataValid), .outEnQ(outEnable)
  );

  assign rdData = outEnable ? qData : 'z;
endmodule

// File: tb/burst_rd_sram_tb_top.sv
module burst_rd_sram_tb_top;
  localparam int DW = 18;
  localparam int GAW = 4;
  localparam int NW = 1 << (GAW + 2);
  localparam int LEN = 8192;

  logic clk = 0;
  logic rst = 1;
  logic kPhase = 0;
  logic legacyMode = 0;
  logic rdSelN = 1;
  logic [GAW-1:0] rdAddr = '0;
  logic wrEn = 0;
  logic [GAW+1:0] wrAddr = '0;
  logic [DW-1:0] wrData = '0;
  wire [DW-1:0] rdData;
  logic dataValid, outEnable;

  burst_rd_sram #(.DW(DW), .GROUP_AW(GAW)) dut_i (
    .clk(clk), .rst(rst), .kPhase(kPhase), .legacyMode(legacyMode),
    .rdSelN(rdSelN), .rdAddr(rdAddr), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdData(rdData), .dataValid(dataValid), .outEnable(outEnable)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc++;

  int checks = 0, fails = 0;
  bit checkOn = 0;
  bit prevOe = 0;
  bit blockM = 0;
  bit expValid [LEN];
  bit rstEdge [LEN];
  logic [DW-1:0] expData [LEN];
  logic [DW-1:0] memM [NW];

  // per-edge comparison, then drive the phase of the next edge
  always @(negedge clk) begin
    if (checkOn && cyc < LEN) begin
      bit ev, eo;
      ev = expValid[cyc];
      eo = !rstEdge[cyc] && (ev || (prevOe && (cyc % 2 != 0)));
      checks++;
      if (dataValid !== ev) begin
        fails++;
        $display("FAIL R6 R1 R3 R4 valid at edge %0d act=%0b exp=%0b", cyc, dataValid, ev);
      end
      checks++;
      if (outEnable !== eo) begin
        fails++;
        $display("FAIL R7 outEnable at edge %0d act=%0b exp=%0b", cyc, outEnable, eo);
      end
      if (ev) begin
        checks++;
        if (rdData !== expData[cyc]) begin
          fails++;
          $display("FAIL R2 R5 R9 data at edge %0d act=%0h exp=%0h", cyc, rdData, expData[cyc]);
        end
      end
      prevOe = eo;
    end
    kPhase = ((cyc + 1) % 2 == 0);
  end

  // one input cycle: request (or not) on the next kPhase edge
  task automatic kslot(input logic selN, input int a);
    int e, lat;
    do @(negedge clk); while ((cyc + 1) % 2 != 0);
    e = cyc + 1;
    rdSelN = selN;
    rdAddr = GAW'(a);
    lat = legacyMode ? 2 : 3;
    if (!selN && !blockM) begin
      blockM = 1;
      for (int i = 0; i < 4; i++) begin
        expValid[e + lat + i] = 1;
        expData[e + lat + i] = memM[a * 4 + i];
      end
    end else begin
      blockM = 0;
    end
    @(negedge clk);
    rdSelN = 1;
    rdAddr = GAW'(a ^ 5);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) kslot(1, 0);
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    wrEn = 1; wrAddr = (GAW+2)'(a); wrData = d;
    memM[a] = d;
    @(negedge clk);
    wrEn = 0;
  endtask

  task automatic doReset(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rst = 1; rdSelN = 1;
      rstEdge[cyc + 1] = 1;
      for (int j = cyc + 1; j < LEN; j++) expValid[j] = 0;
    end
    blockM = 0;
    @(negedge clk);
    rst = 0;
  endtask

  initial begin
    for (int i = 0; i < LEN; i++) begin
      expValid[i] = 0; rstEdge[i] = 0; expData[i] = '0;
    end
    rst = 1;
    // R9: fill the array through the write port
    for (int a = 0; a < NW; a++) wr(a, DW'((a * 1103 + 77) % (1 << DW)));
    @(negedge clk);
    rst = 0;
    @(negedge clk);
    checkOn = 1;
    // R8: idle outputs after reset
    checks++;
    if (dataValid !== 0 || outEnable !== 0) begin
      fails++;
      $display("FAIL R8 after reset act=%0b%0b exp=00", dataValid, outEnable);
    end
    for (int m = 0; m < 2; m++) begin
      idle(4);
      legacyMode = m[0];
      idle(4);
      kslot(0, 5);            // R1 R5: single read, address changes afterwards
      idle(5);
      kslot(0, 7);            // R3: second request dropped
      kslot(0, 12);
      idle(5);
      for (int g = 0; g < 16; g++) begin  // R4 R2: gapless sweep of every group
        kslot(0, g);
        kslot(1, 0);
      end
      idle(5);
      for (int k = 1; k <= 6; k++) kslot(0, k);  // continuous select low
      idle(5);
    end
    // R9: overwrite one word, then read it back
    wr(9 * 4 + 2, 18'h2a5c3);
    kslot(0, 9);
    idle(5);
    // R8: reset in the middle of a burst
    kslot(0, 3);
    @(negedge clk);
    @(negedge clk);
    doReset(2);
    @(negedge clk);
    checks++;
    if (dataValid !== 0 || outEnable !== 0) begin
      fails++;
      $display("FAIL R8 mid-burst reset act=%0b%0b exp=00", dataValid, outEnable);
    end
    idle(4);
    kslot(0, 14);
    idle(6);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule